// File: doc/BRIEF.md
# Serial MII PHY-Side Lane Interface

This block is the PHY end of one port of a serial media-independent interface. It runs from a single 125 MHz reference clock that the MAC also uses. It exchanges ten-bit segments with the MAC on two single-wire paths. A SYNC pulse, shared by every port of the device, marks bit 0 of each segment. On the transmit wire the block gathers the error flag, the enable flag and a data byte, and presents them as one parallel word with a one-cycle strobe. On the receive wire it sends carrier, data-valid and either a data byte or, when no frame is in flight, a status byte describing the link.

At 10 Mbps every segment is sent ten times in a row. The block loads a new receive segment only at the first copy of each group of ten and repeats it for the other nine. On transmit it accepts only one copy out of each group of ten. Collisions are not reported. The MAC infers a collision on its own when it sees carrier or data-valid while it is itself transmitting.

Top module: `smii_phy_lane`

## Requirements
- R1: Before the first SYNC after reset, `rxd_o` stays low and `tx_strobe_o` stays low. A cycle with `sync_i` high is bit 0 of a segment. Without SYNC, the bit position keeps counting from 0 to 9 and then wraps to 0.
- R2: Transmit bit 0 is the error flag and bit 1 is the enable flag. Bits 2 to 9 are data bits 0 to 7, least significant bit first. The recovered word appears with `tx_strobe_o` high for one cycle, in the cycle after bit 9.
- R3: When `rx_dv_i` is high at bit 0, the receive segment is: bit 0 = `rx_crs_i`, bit 1 = 1, bits 2 to 9 = `rx_data_i` bits 0 to 7.
- R4: When `rx_dv_i` is low at bit 0, the receive segment is: bit 0 = `rx_crs_i`, bit 1 = 0. Bits 2 to 9 carry a status byte whose bits are:
  - bit 0 = `prev_rx_err_i`
  - bit 1 = `speed_100_i` (1 = 100 Mbps, 0 = 10 Mbps)
  - bit 2 = `full_duplex_i` (1 = full duplex)
  - bit 3 = `link_up_i` (1 = link up)
  - bit 4 = `jabber_i`
  - bit 5 = `nibble_ok_i`
  - bit 6 = `false_carrier_i`
  - bit 7 = 1
- R5: Receive inputs are sampled only in the bit-0 cycle. Changes to them during bits 1 to 9 do not alter the segment being sent.
- R6: With `speed_100_i` low, a receive segment is loaded only at the first of every ten consecutive segments and repeated unchanged for the next nine. `tx_strobe_o` fires only for the first segment of each group of ten.
- R7: A SYNC that arrives before bit 9 of the current segment is reached restarts the segment at bit 0. The unfinished transmit segment produces no strobe.
- R8: Between strobes, `tx_er_o`, `tx_en_o` and `tx_data_o` hold their last values.
- R9: With `speed_100_i` high, every segment loads new receive inputs and every complete transmit segment produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Shared segment-start pulse |
| speed_100_i | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps with tenfold repetition |
| txd_i | input | 1 | Serial transmit data from the MAC |
| tx_strobe_o | output | 1 | One-cycle pulse when a new transmit word is presented |
| tx_er_o | output | 1 | Recovered transmit error flag |
| tx_en_o | output | 1 | Recovered transmit enable flag |
| tx_data_o | output | 8 | Recovered transmit byte |
| rx_crs_i | input | 1 | Carrier sense for the receive segment |
| rx_dv_i | input | 1 | Receive data valid; low selects the status byte |
| rx_data_i | input | 8 | Receive data byte |
| full_duplex_i | input | 1 | Duplex status |
| link_up_i | input | 1 | Link status |
| prev_rx_err_i | input | 1 | Receive error seen in the previous frame |
| jabber_i | input | 1 | Jabber flag |
| nibble_ok_i | input | 1 | Upper-nibble-valid flag |
| false_carrier_i | input | 1 | False-carrier flag |
| rxd_o | output | 1 | Serial receive data to the MAC |

## Verification
The embedded assertions check the following on every cycle:
- the transmit strobe only follows a bit-9 cycle;
- the transmit outputs never move without a strobe;
- the receive segment register is frozen outside bit 0;
- a status segment always carries its fixed top bit;
- a SYNC always restarts the bit counter;
- the repeat counter stays in range;
- at 100 Mbps every segment is treated as a first copy.

Some behaviour can only be shown by the bench's scenarios, with the receive wire looped back into the transmit wire. That includes exact bit placement of data and status bytes, byte-exact round trips in both speeds, the nine ignored copies at 10 Mbps, and the discarded partial segment after an early SYNC.

// File: rtl/smii_lane_pkg.sv
package smii_lane_pkg;

    localparam int SEG_LEN = 10;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = $clog2(SEG_LEN);

    typedef struct packed {
        logic              er;
        logic              en;
        logic [BYTE_W-1:0] data;
    } tx_word_t;

    typedef struct packed {
        logic false_car;
        logic nib_ok;
        logic jabber;
        logic link;
        logic duplex;
        logic speed;
        logic prev_err;
    } rx_stat_t;

    // Build a receive segment, bit 0 first on the wire.
    function automatic logic [SEG_LEN-1:0] pack_rx_seg(
        input logic              crs,
        input logic              dv,
        input logic [BYTE_W-1:0] data,
        input rx_stat_t          st
    );
        logic [BYTE_W-1:0] body;
        body = dv ? data
                  : {1'b1, st.false_car, st.nib_ok, st.jabber,
                     st.link, st.duplex, st.speed, st.prev_err};
        return {body, dv, crs};
    endfunction

endpackage

// File: rtl/smii_seg_timer.sv
module smii_seg_timer
    import smii_lane_pkg::*;
#(
    parameter int COPIES = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_i,
    input  logic             speed100_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             aligned_o,
    output logic             load_o,
    output logic             commit_o
);
    localparam int REP_W = (COPIES > 1) ? $clog2(COPIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SEG_LEN - 1);
    localparam logic [REP_W-1:0] REP_LAST = REP_W'(COPIES - 1);

    logic [IDX_W-1:0] cnt_q;
    logic [REP_W-1:0] rep_q;
    logic             aligned_q;
    logic             first_q;
    logic             seg_ok_q;
    logic             seg_start;

    assign idx_o     = sync_i ? '0 : cnt_q;
    assign aligned_o = sync_i | aligned_q;
    assign seg_start = aligned_o && (idx_o == '0);
    assign load_o    = seg_start && (speed100_i || (rep_q == '0));
    assign commit_o  = (idx_o == LAST) && seg_ok_q && first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            rep_q     <= '0;
            aligned_q <= 1'b0;
            first_q   <= 1'b0;
            seg_ok_q  <= 1'b0;
        end else begin
            if (sync_i)
                cnt_q <= IDX_W'(1);
            else if (cnt_q == LAST)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + IDX_W'(1);

            if (sync_i)
                aligned_q <= 1'b1;

            if (idx_o == '0)
                seg_ok_q <= aligned_o;

            if (seg_start) begin
                first_q <= speed100_i || (rep_q == '0);
                if (speed100_i || rep_q == REP_LAST)
                    rep_q <= '0;
                else
                    rep_q <= rep_q + REP_W'(1);
            end
        end
    end

    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> (cnt_q == IDX_W'(1)));                          // R7
    AST_REP_RANGE: assert property (@(posedge clk) disable iff (rst)
        rep_q <= REP_LAST);                                        // R6
    AST_FAST_EVERY_SEG: assert property (@(posedge clk) disable iff (rst)
        (speed100_i && seg_start) |=> first_q);                    // R9

endmodule

// File: rtl/smii_tx_deser.sv
module smii_tx_deser
    import smii_lane_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             commit_i,
    input  logic             txd_i,
    output tx_word_t         word_o,
    output logic             strobe_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SEG_LEN - 1);

    logic [SEG_LEN-2:0] sh_q;
    logic [SEG_LEN-1:0] full;
    tx_word_t           word_q;
    logic               stb_q;

    assign full     = {txd_i, sh_q};
    assign word_o   = word_q;
    assign strobe_o = stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            word_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            for (int b = 0; b < SEG_LEN - 1; b++)
                if (idx_i == IDX_W'(b))
                    sh_q[b] <= txd_i;
            stb_q <= commit_i;
            if (commit_i) begin
                word_q.er   <= full[0];
                word_q.en   <= full[1];
                word_q.data <= full[SEG_LEN-1:2];
            end
        end
    end

    AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        stb_q |-> $past(idx_i == LAST));                           // R2
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb_q |-> $stable(word_q));                               // R8

endmodule

// File: rtl/smii_rx_ser.sv
module smii_rx_ser
    import smii_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              aligned_i,
    input  logic              load_i,
    input  logic              crs_i,
    input  logic              dv_i,
    input  logic [BYTE_W-1:0] data_i,
    input  rx_stat_t          stat_i,
    output logic              rxd_o
);
    logic [SEG_LEN-1:0] hold_q;
    logic [SEG_LEN-1:0] fresh;
    logic [SEG_LEN-1:0] src;
    logic               start;

    assign fresh = pack_rx_seg(crs_i, dv_i, data_i, stat_i);
    assign src   = load_i ? fresh : hold_q;
    assign start = aligned_i && (idx_i == '0);

    always_comb begin
        if (!aligned_i)
            rxd_o = 1'b0;
        else if (idx_i == '0)
            rxd_o = src[0];
        else
            rxd_o = hold_q[idx_i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (start)
            hold_q <= src;
    end

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (idx_i != '0) |=> $stable(hold_q));                        // R5
    AST_STATUS_MARK: assert property (@(posedge clk) disable iff (rst)
        (load_i && !dv_i) |=> hold_q[SEG_LEN-1]);                  // R4

endmodule

// File: rtl/smii_phy_lane.sv
module smii_phy_lane
    import smii_lane_pkg::*;
#(
    parameter int COPIES = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_i,
    input  logic       speed_100_i,
    input  logic       txd_i,
    output logic       tx_strobe_o,
    output logic       tx_er_o,
    output logic       tx_en_o,
    output logic [7:0] tx_data_o,
    input  logic       rx_crs_i,
    input  logic       rx_dv_i,
    input  logic [7:0] rx_data_i,
    input  logic       full_duplex_i,
    input  logic       link_up_i,
    input  logic       prev_rx_err_i,
    input  logic       jabber_i,
    input  logic       nibble_ok_i,
    input  logic       false_carrier_i,
    output logic       rxd_o
);
    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             load;
    logic             commit;
    tx_word_t         tx_word;
    rx_stat_t         stat;

    always_comb begin
        stat.false_car = false_carrier_i;
        stat.nib_ok    = nibble_ok_i;
        stat.jabber    = jabber_i;
        stat.link      = link_up_i;
        stat.duplex    = full_duplex_i;
        stat.speed     = speed_100_i;
        stat.prev_err  = prev_rx_err_i;
    end

    smii_seg_timer #(.COPIES(COPIES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .sync_i     (sync_i),
        .speed100_i (speed_100_i),
        .idx_o      (idx),
        .aligned_o  (aligned),
        .load_o     (load),
        .commit_o   (commit)
    );

    smii_tx_deser u_tx (
        .clk      (clk),
        .rst      (rst),
        .idx_i    (idx),
        .commit_i (commit),
        .txd_i    (txd_i),
        .word_o   (tx_word),
        .strobe_o (tx_strobe_o)
    );

    smii_rx_ser u_rx (
        .clk       (clk),
        .rst       (rst),
        .idx_i     (idx),
        .aligned_i (aligned),
        .load_i    (load),
        .crs_i     (rx_crs_i),
        .dv_i      (rx_dv_i),
        .data_i    (rx_data_i),
        .stat_i    (stat),
        .rxd_o     (rxd_o)
    );

    assign tx_er_o   = tx_word.er;
    assign tx_en_o   = tx_word.en;
    assign tx_data_o = tx_word.data;

endmodule

// File: tb/test_smii_phy_lane.sv
module test_smii_phy_lane;
    localparam int CLK_PERIOD = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       sync_i;
    logic       speed_100_i;
    logic       txd_i;
    logic       tx_strobe_o;
    logic       tx_er_o;
    logic       tx_en_o;
    logic [7:0] tx_data_o;
    logic       rx_crs_i;
    logic       rx_dv_i;
    logic [7:0] rx_data_i;
    logic       full_duplex_i;
    logic       link_up_i;
    logic       prev_rx_err_i;
    logic       jabber_i;
    logic       nibble_ok_i;
    logic       false_carrier_i;
    logic       rxd_o;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Loopback: the serialized receive wire feeds the transmit deserializer.
    assign txd_i = rxd_o;

    smii_phy_lane i_smii_phy_lane (
        .clk             (clk),
        .rst             (rst),
        .sync_i          (sync_i),
        .speed_100_i     (speed_100_i),
        .txd_i           (txd_i),
        .tx_strobe_o     (tx_strobe_o),
        .tx_er_o         (tx_er_o),
        .tx_en_o         (tx_en_o),
        .tx_data_o       (tx_data_o),
        .rx_crs_i        (rx_crs_i),
        .rx_dv_i         (rx_dv_i),
        .rx_data_i       (rx_data_i),
        .full_duplex_i   (full_duplex_i),
        .link_up_i       (link_up_i),
        .prev_rx_err_i   (prev_rx_err_i),
        .jabber_i        (jabber_i),
        .nibble_ok_i     (nibble_ok_i),
        .false_carrier_i (false_carrier_i),
        .rxd_o           (rxd_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // st = {false_carrier, nibble_ok, jabber, link, duplex, prev_err}
    function automatic logic [9:0] exp_seg(input logic crs, input logic dv,
                                           input logic [7:0] d, input logic [5:0] st,
                                           input logic spd);
        logic [7:0] body;
        if (dv) body = d;
        else    body = {1'b1, st[5], st[4], st[3], st[2], st[1], spd, st[0]};
        return {body, dv, crs};
    endfunction

    task automatic drive_rx(input logic crs, input logic dv, input logic [7:0] d,
                            input logic [5:0] st);
        rx_crs_i        = crs;
        rx_dv_i         = dv;
        rx_data_i       = d;
        false_carrier_i = st[5];
        nibble_ok_i     = st[4];
        jabber_i        = st[3];
        link_up_i       = st[2];
        full_duplex_i   = st[1];
        prev_rx_err_i   = st[0];
    endtask

    // One full segment, entered and left at a negative clock edge.
    task automatic run_seg(input logic crs, input logic dv, input logic [7:0] d,
                           input logic [5:0] st, input logic [9:0] exp_w,
                           input logic exp_stb, input logic [9:0] exp_tx,
                           input string req);
        logic [9:0] got;
        drive_rx(crs, dv, d, st);
        sync_i = 1'b1;
        #1 got[0] = rxd_o;
        for (int b = 1; b < 10; b++) begin
            @(negedge clk);
            sync_i = 1'b0;
            // R5: scramble inputs after bit 0; must not disturb the segment
            if (b == 1) drive_rx(~crs, ~dv, ~d, ~st);
            #1 got[b] = rxd_o;
        end
        @(negedge clk);
        chk(got == exp_w, req, 32'(got), 32'(exp_w));
        chk(tx_strobe_o == exp_stb, "R2 strobe", 32'(tx_strobe_o), 32'(exp_stb));
        chk({tx_data_o, tx_en_o, tx_er_o} == exp_tx, "R2 tx word",
            32'({tx_data_o, tx_en_o, tx_er_o}), 32'(exp_tx));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [9:0] w;
        logic [9:0] last_w;
        rst = 1'b1;
        sync_i = 1'b0;
        speed_100_i = 1'b1;
        drive_rx(1'b1, 1'b1, 8'hFF, 6'h3F);
        repeat (3) @(negedge clk);
        // Reset state
        chk(tx_strobe_o == 1'b0, "R1 reset strobe", 32'(tx_strobe_o), 0);
        chk({tx_data_o, tx_en_o, tx_er_o} == 10'h0, "R1 reset tx",
            32'({tx_data_o, tx_en_o, tx_er_o}), 0);
        rst = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(rxd_o == 1'b0, "R1 rxd before sync", 32'(rxd_o), 0);
            chk(tx_strobe_o == 1'b0, "R1 strobe before sync", 32'(tx_strobe_o), 0);
        end

        // R3 / R9: 100 Mbps data sweep, every byte round-trips
        for (int d = 0; d < 256; d++) begin
            logic crs;
            crs = d[0] ^ d[3];
            w = exp_seg(crs, 1'b1, 8'(d), 6'h00, 1'b1);
            run_seg(crs, 1'b1, 8'(d), 6'h00, w, 1'b1, w, "R3 data segment");
            last_w = w;
        end

        // R4: status sweep at 100 Mbps
        for (int s = 0; s < 64; s++) begin
            w = exp_seg(s[0], 1'b0, 8'hA5, 6'(s), 1'b1);
            run_seg(s[0], 1'b0, 8'hA5, 6'(s), w, 1'b1, w, "R4 status segment");
            last_w = w;
        end

        // R7: early SYNC after 5 bits; partial segment gives no strobe
        drive_rx(1'b1, 1'b1, 8'h3C, 6'h00);
        sync_i = 1'b1;
        for (int b = 1; b < 5; b++) begin
            @(negedge clk);
            sync_i = 1'b0;
            chk(tx_strobe_o == 1'b0, "R7 no strobe on partial", 32'(tx_strobe_o), 0);
            chk({tx_data_o, tx_en_o, tx_er_o} == last_w, "R8 hold during partial",
                32'({tx_data_o, tx_en_o, tx_er_o}), 32'(last_w));
        end
        @(negedge clk);
        w = exp_seg(1'b0, 1'b1, 8'hC3, 6'h00, 1'b1);
        run_seg(1'b0, 1'b1, 8'hC3, 6'h00, w, 1'b1, w, "R7 realigned segment");

        // R6 / R8: 10 Mbps groups of ten copies
        speed_100_i = 1'b0;
        for (int g = 0; g < 12; g++) begin
            logic       dv;
            logic [7:0] d;
            logic [5:0] st;
            dv = (g % 3) != 0;
            d  = 8'(g * 21 + 7);
            st = 6'(g * 5);
            w  = exp_seg(g[1], dv, d, st, 1'b0);
            for (int c = 0; c < 10; c++) begin
                if (c == 0)
                    run_seg(g[1], dv, d, st, w, 1'b1, w, "R6 first copy");
                else
                    // inputs differ on copies 1..9; serializer must repeat copy 0
                    run_seg(~g[1], ~dv, ~d, ~st, w, 1'b0, w, "R6 repeated copy");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule